// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Data Path

This block is the arithmetic core of a fixed-point signal processor. Two operand buses each feed a pair of 24-bit source registers. A signed 24×24 multiplier reads one pair of those registers, chosen by a select code. It treats both operands as two's-complement fractions and doubles the product, so the binary point lines up with the accumulator. Two 56-bit accumulators hold running sums: an 8-bit guard extension, a 24-bit upper word and a 24-bit lower word. The guard bits let many products be summed before the value leaves the representable fraction range.

An opcode, valid strobe and destination select start one operation per cycle. The operations are clear, multiply, multiply-accumulate, multiply-accumulate with rounding, and round only. The rounding is convergent (round half to even) into the upper word, and the lower word is then cleared. A readout port presents either accumulator as a 24-bit word. That word is saturated to the most positive or most negative fraction whenever the guard bits hold significant data, and a flag marks the clipped case.

Top module: `mac_dalu`

## Requirements
- R1: While rst_n is low at a rising edge, both accumulators and all four source registers become zero. After reset, rd_data reads 0 and rd_limit reads 0.
- R2: A load writes the bus word into X0 when ld_x_sel is 0 and into X1 when it is 1, and into Y0 or Y1 in the same way from the Y bus. An operation issued in the next cycle uses the new value.
- R3: Opcode 2 (multiply) writes the product into the accumulator selected by op_dst (0 = A, 1 = B), visible after one rising edge. The product is the signed 24×24 product shifted left one place and sign-extended to 56 bits. The other accumulator is unchanged.
- R4: Opcode 3 (multiply-accumulate) adds the product to the selected accumulator, with a full 56-bit wrap. It accepts one operation per cycle, back to back.
- R5: Opcode 1 (clear) sets the selected accumulator to zero and leaves the other unchanged.
- R6: Opcode 4 (multiply-accumulate-round) forms the sum as in R4, adds 2^23, clears bit 24 when the discarded low 24 bits of the sum were exactly 0x800000, and writes the result with its low 24 bits zero.
- R7: Opcode 5 (round) applies the rounding of R6 to the selected accumulator alone.
- R8: op_src selects the multiplier pair: 0 = X0·Y0, 1 = X0·Y1, 2 = X1·Y0, 3 = X1·Y1.
- R9: rd_sel picks accumulator A (0) or B (1) for readout. When bits 55 to 47 are all equal, rd_data is bits 47 to 24 and rd_limit is 0.
- R10: When bits 55 to 47 are not all equal, rd_data is 0x7FFFFF for a positive accumulator (bit 55 = 0) or 0x800000 for a negative one, and rd_limit is 1.
- R11: With op_valid low, or with an undefined opcode (0, 6, 7), neither accumulator changes.
- R12: The product of 0x800000 by 0x800000 is held as +2^47 (0x00800000000000) without wrapping, and reading it out saturates per R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_x | input | 1 | Load strobe for the X source registers |
| ld_x_sel | input | 1 | X register select: 0 = X0, 1 = X1 |
| x_bus | input | 24 | X data bus word |
| ld_y | input | 1 | Load strobe for the Y source registers |
| ld_y_sel | input | 1 | Y register select: 0 = Y0, 1 = Y1 |
| y_bus | input | 24 | Y data bus word |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (see R3 to R7, R11) |
| op_src | input | 2 | Multiplier source pair (R8) |
| op_dst | input | 1 | Destination accumulator: 0 = A, 1 = B |
| rd_sel | input | 1 | Readout accumulator: 0 = A, 1 = B |
| rd_data | output | 24 | Limited 24-bit readout |
| rd_limit | output | 1 | High when rd_data was saturated |
| acc_a | output | 56 | Full contents of accumulator A |
| acc_b | output | 56 | Full contents of accumulator B |

## Verification
The bench builds the block with its default parameters: 24-bit operands and 8 guard bits, giving 56-bit accumulators. At that size, hand-picked operand values reach every interesting case. Products of 0x000001 and 0x000003 land exactly on the rounding half-way point and on either side of it. Repeated near-full-scale products fill the guard bits in both signs, and the one product that exceeds unit magnitude (−1 × −1) is reached as well.

// File: rtl/mac_dalu_pkg.sv
// Shared opcode encoding for the multiply-accumulate data path.
// Assumes every unit decodes the 3-bit op_code field against these values.
package mac_dalu_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_CLR  = 3'd1,
        OP_MPY  = 3'd2,
        OP_MAC  = 3'd3,
        OP_MACR = 3'd4,
        OP_RND  = 3'd5
    } mac_op_e;

    localparam int unsigned NUM_ACC = 2;

endpackage

// File: rtl/mac_opnd_regs.sv
// Source operand bank: two X and two Y registers loaded from their buses,
// plus the pair multiplexer that feeds the multiplier.
// Assumes a load and an operation may share a cycle; the operation then
// sees the value held before the edge.
module mac_opnd_regs #(
    parameter int unsigned OPW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_x,
    input  logic           ld_x_sel,
    input  logic [OPW-1:0] x_bus,
    input  logic           ld_y,
    input  logic           ld_y_sel,
    input  logic [OPW-1:0] y_bus,
    input  logic [1:0]     src_sel,
    output logic [OPW-1:0] mul_a,
    output logic [OPW-1:0] mul_b
);

    logic [OPW-1:0] x_q [2];
    logic [OPW-1:0] y_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        // X register g: load from the X bus when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                x_q[g] <= '0;
            else if (ld_x && (ld_x_sel == 1'(g)))
                x_q[g] <= x_bus;
        end

        // Y register g: load from the Y bus when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                y_q[g] <= '0;
            else if (ld_y && (ld_y_sel == 1'(g)))
                y_q[g] <= y_bus;
        end
    end

    // Pair select: upper select bit picks X, lower picks Y
    always_comb begin
        mul_a = x_q[src_sel[1]];
        mul_b = y_q[src_sel[0]];
    end

endmodule

// File: rtl/mac_mult.sv
// Signed fractional multiplier: OPW x OPW two's-complement product, sign
// extended to the accumulator width and doubled to align the binary point.
// Assumes ACCW >= 2*OPW + 1 so that -1 x -1 does not wrap.
module mac_mult #(
    parameter int unsigned OPW  = 24,
    parameter int unsigned ACCW = 56
) (
    input  logic [OPW-1:0]  mul_a,
    input  logic [OPW-1:0]  mul_b,
    output logic [ACCW-1:0] prod
);

    localparam int unsigned PW  = 2 * OPW;
    localparam int unsigned EXT = ACCW - PW;

    logic signed [PW-1:0] raw;
    logic [ACCW-1:0]      wide;

    // Full signed product, extension, then one-place left shift
    always_comb begin
        raw  = $signed(mul_a) * $signed(mul_b);
        wide = {{EXT{raw[PW-1]}}, raw};
        prod = {wide[ACCW-2:0], 1'b0};
    end

endmodule

// File: rtl/mac_acc_unit.sv
// Two accumulators with clear, multiply, accumulate, accumulate-and-round
// and round-only updates. One update per cycle to the addressed accumulator.
// Assumes prod is already aligned to the accumulator binary point.
module mac_acc_unit
    import mac_dalu_pkg::*;
#(
    parameter int unsigned OPW  = 24,
    parameter int unsigned ACCW = 56
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic            op_dst,
    input  logic [ACCW-1:0] prod,
    output logic [ACCW-1:0] acc_a,
    output logic [ACCW-1:0] acc_b
);

    localparam logic [OPW-1:0]  HALF_LO  = {1'b1, {(OPW-1){1'b0}}};
    localparam logic [ACCW-1:0] HALF_ADD = ACCW'(HALF_LO);

    logic [ACCW-1:0] acc_q [NUM_ACC];

    // Convergent rounding into the upper word; ties go to the even value
    function automatic logic [ACCW-1:0] round_conv(input logic [ACCW-1:0] v);
        logic [ACCW-1:0] t;
        t = v + HALF_ADD;
        if (v[OPW-1:0] == HALF_LO)
            t[OPW] = 1'b0;
        t[OPW-1:0] = '0;
        return t;
    endfunction

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        logic            hit;
        logic [ACCW-1:0] sum;
        logic [ACCW-1:0] nxt;

        // Next-value selection for accumulator g
        always_comb begin
            hit = op_valid && (op_dst == 1'(g));
            sum = acc_q[g] + prod;
            case (op_code)
                OP_CLR:  nxt = '0;
                OP_MPY:  nxt = prod;
                OP_MAC:  nxt = sum;
                OP_MACR: nxt = round_conv(sum);
                OP_RND:  nxt = round_conv(acc_q[g]);
                default: nxt = acc_q[g];
            endcase
        end

        // Accumulator g storage
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[g] <= '0;
            else if (hit)
                acc_q[g] <= nxt;
        end
    end

    // Expose both accumulators
    always_comb begin
        acc_a = acc_q[0];
        acc_b = acc_q[1];
    end

endmodule

// File: rtl/mac_limiter.sv
// Readout limiter: reduces an accumulator to its upper word, clipping to
// the extreme fractions when the guard bits carry magnitude.
// Assumes ACCW > 2*OPW.
module mac_limiter #(
    parameter int unsigned OPW  = 24,
    parameter int unsigned ACCW = 56
) (
    input  logic [ACCW-1:0] acc,
    output logic [OPW-1:0]  rd_data,
    output logic            rd_limit
);

    localparam int unsigned    TOP     = 2 * OPW - 1;
    localparam logic [OPW-1:0] POS_MAX = {1'b0, {(OPW-1){1'b1}}};
    localparam logic [OPW-1:0] NEG_MAX = {1'b1, {(OPW-1){1'b0}}};

    logic [ACCW-1-TOP:0] guard;
    logic                in_range;

    // Range test on guard bits plus the upper-word sign, then clip
    always_comb begin
        guard    = acc[ACCW-1:TOP];
        in_range = (&guard) || !(|guard);
        rd_limit = !in_range;
        if (in_range)
            rd_data = acc[TOP:OPW];
        else
            rd_data = acc[ACCW-1] ? NEG_MAX : POS_MAX;
    end

endmodule

// File: rtl/mac_dalu.sv
// Top of the fixed-point multiply-accumulate data path: operand bank,
// multiplier, two accumulators and a limited 24-bit readout.
// Assumes a single clock domain and one operation per cycle.
module mac_dalu #(
    parameter int unsigned OPW   = 24,
    parameter int unsigned GUARD = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_x,
    input  logic                       ld_x_sel,
    input  logic [OPW-1:0]             x_bus,
    input  logic                       ld_y,
    input  logic                       ld_y_sel,
    input  logic [OPW-1:0]             y_bus,
    input  logic                       op_valid,
    input  logic [2:0]                 op_code,
    input  logic [1:0]                 op_src,
    input  logic                       op_dst,
    input  logic                       rd_sel,
    output logic [OPW-1:0]             rd_data,
    output logic                       rd_limit,
    output logic [2*OPW+GUARD-1:0]     acc_a,
    output logic [2*OPW+GUARD-1:0]     acc_b
);

    localparam int unsigned ACCW = 2 * OPW + GUARD;

    logic [OPW-1:0]  mul_a;
    logic [OPW-1:0]  mul_b;
    logic [ACCW-1:0] prod;
    logic [ACCW-1:0] rd_acc;

    mac_opnd_regs #(.OPW(OPW)) u_opnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_x     (ld_x),
        .ld_x_sel (ld_x_sel),
        .x_bus    (x_bus),
        .ld_y     (ld_y),
        .ld_y_sel (ld_y_sel),
        .y_bus    (y_bus),
        .src_sel  (op_src),
        .mul_a    (mul_a),
        .mul_b    (mul_b)
    );

    mac_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
        .mul_a (mul_a),
        .mul_b (mul_b),
        .prod  (prod)
    );

    mac_acc_unit #(.OPW(OPW), .ACCW(ACCW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_dst   (op_dst),
        .prod     (prod),
        .acc_a    (acc_a),
        .acc_b    (acc_b)
    );

    // Readout source select
    always_comb rd_acc = rd_sel ? acc_b : acc_a;

    mac_limiter #(.OPW(OPW), .ACCW(ACCW)) u_lim (
        .acc      (rd_acc),
        .rd_data  (rd_data),
        .rd_limit (rd_limit)
    );

endmodule

// File: rtl/mac_dalu_chk.sv
// Property checker for mac_dalu, attached through bind.
// Assumes the port names of the top module.
module mac_dalu_chk #(
    parameter int unsigned OPW  = 24,
    parameter int unsigned ACCW = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic            op_dst,
    input logic [OPW-1:0]  rd_data,
    input logic            rd_limit,
    input logic [ACCW-1:0] acc_a,
    input logic [ACCW-1:0] acc_b
);

    localparam logic [OPW-1:0] POS_MAX = {1'b0, {(OPW-1){1'b1}}};
    localparam logic [OPW-1:0] NEG_MAX = {1'b1, {(OPW-1){1'b0}}};

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_a == '0) && (acc_b == '0));

    // R5
    clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 3'd1) && !op_dst |=> acc_a == '0);

    // R3
    other_acc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_dst |=> $stable(acc_b));

    // R6
    round_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 3'd4) && op_dst |=> acc_b[OPW-1:0] == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc_a) && $stable(acc_b));

    // R10
    limit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_limit |-> (rd_data == POS_MAX) || (rd_data == NEG_MAX));

endmodule

bind mac_dalu mac_dalu_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_dst   (op_dst),
    .rd_data  (rd_data),
    .rd_limit (rd_limit),
    .acc_a    (acc_a),
    .acc_b    (acc_b)
);

// File: tb/sim_mac_dalu.sv
// Scoreboard bench for mac_dalu: the driver keeps a reference model and
// queues expected accumulator contents; a monitor compares them each cycle.
module sim_mac_dalu;

    localparam int OPW  = 24;
    localparam int ACCW = 56;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_x = 1'b0, ld_x_sel = 1'b0, ld_y = 1'b0, ld_y_sel = 1'b0;
    logic [OPW-1:0]  x_bus = '0, y_bus = '0;
    logic            op_valid = 1'b0;
    logic [2:0]      op_code = '0;
    logic [1:0]      op_src = '0;
    logic            op_dst = 1'b0;
    logic            rd_sel = 1'b0;
    logic [OPW-1:0]  rd_data;
    logic            rd_limit;
    logic [ACCW-1:0] acc_a, acc_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [OPW-1:0]  mx [2];
    logic [OPW-1:0]  my [2];
    logic [ACCW-1:0] ma, mb;

    int              q_due [$];
    logic [ACCW-1:0] q_a [$];
    logic [ACCW-1:0] q_b [$];
    string           q_req [$];

    mac_dalu u0 (.*);

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop items due this cycle and compare accumulators
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            checks++;
            if (acc_a !== q_a[0] || acc_b !== q_b[0]) begin
                errors++;
                $display("FAIL %s acc_a=%h acc_b=%h expected %h %h",
                         q_req[0], acc_a, acc_b, q_a[0], q_b[0]);
            end
            void'(q_due.pop_front());
            void'(q_a.pop_front());
            void'(q_b.pop_front());
            void'(q_req.pop_front());
        end
    end

    function automatic logic [ACCW-1:0] m_prod(input logic [1:0] s);
        logic signed [ACCW-1:0] a, b;
        a = ACCW'($signed(mx[s[1]]));
        b = ACCW'($signed(my[s[0]]));
        return ACCW'(a * b * 2);
    endfunction

    function automatic logic [ACCW-1:0] m_round(input logic [ACCW-1:0] v);
        logic [ACCW-1:0] t;
        t = v + 56'h800000;
        if (v[23:0] == 24'h800000) t[24] = 1'b0;
        t[23:0] = '0;
        return t;
    endfunction

    task automatic load(input bit is_y, input bit sel, input logic [OPW-1:0] v);
        @(negedge clk);
        op_valid = 1'b0;
        ld_x = !is_y; ld_y = is_y;
        ld_x_sel = sel; ld_y_sel = sel;
        x_bus = v; y_bus = v;
        if (is_y) my[sel] = v; else mx[sel] = v;
    endtask

    task automatic issue(input bit vld, input logic [2:0] code, input logic [1:0] src,
                         input bit dst, input string req);
        logic [ACCW-1:0] cur, p, nv;
        @(negedge clk);
        ld_x = 1'b0; ld_y = 1'b0;
        op_valid = vld; op_code = code; op_src = src; op_dst = dst;
        cur = dst ? mb : ma;
        p = m_prod(src);
        case (code)
            3'd1: nv = '0;
            3'd2: nv = p;
            3'd3: nv = cur + p;
            3'd4: nv = m_round(cur + p);
            3'd5: nv = m_round(cur);
            default: nv = cur;
        endcase
        if (vld) begin
            if (dst) mb = nv; else ma = nv;
        end
        q_due.push_back(cyc + 1);
        q_a.push_back(ma);
        q_b.push_back(mb);
        q_req.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0; ld_x = 1'b0; ld_y = 1'b0;
    endtask

    task automatic check_rd(input bit sel, input string req);
        logic [ACCW-1:0] v;
        logic [OPW-1:0]  ed;
        logic            el;
        idle();
        rd_sel = sel;
        #2;
        v = sel ? mb : ma;
        if (v[55:47] == 9'h000 || v[55:47] == 9'h1FF) begin
            ed = v[47:24]; el = 1'b0;
        end else begin
            ed = v[55] ? 24'h800000 : 24'h7FFFFF; el = 1'b1;
        end
        checks++;
        if (rd_data !== ed || rd_limit !== el) begin
            errors++;
            $display("FAIL %s rd_data=%h rd_limit=%b expected %h %b",
                     req, rd_data, rd_limit, ed, el);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mx[0] = '0; mx[1] = '0; my[0] = '0; my[1] = '0;
        ma = '0; mb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at ports
        check_rd(1'b0, "R1");
        check_rd(1'b1, "R1");

        // R2, R8: load four distinct operands
        load(1'b0, 1'b0, 24'h400000);
        load(1'b1, 1'b0, 24'h400000);
        load(1'b0, 1'b1, 24'h200000);
        load(1'b1, 1'b1, 24'hC00000);
        // R3: multiply X0*Y0 into A
        issue(1, 3'd2, 2'd0, 0, "R3");
        // R4, R8: back-to-back accumulate X1*Y1 then X1*Y0 into A
        issue(1, 3'd3, 2'd3, 0, "R4");
        issue(1, 3'd3, 2'd2, 0, "R4");
        // R8: X0*Y1 into B
        issue(1, 3'd2, 2'd1, 1, "R8");
        check_rd(1'b0, "R9");
        check_rd(1'b1, "R9");
        // R5: clear A, B kept
        issue(1, 3'd1, 2'd0, 0, "R5");
        // R11: valid low and undefined codes hold state
        issue(0, 3'd2, 2'd0, 1, "R11");
        issue(1, 3'd7, 2'd0, 1, "R11");
        issue(1, 3'd0, 2'd3, 0, "R11");
        issue(1, 3'd6, 2'd3, 1, "R11");

        // R7: exact half with even upper word rounds down
        load(1'b0, 1'b0, 24'h000001);
        issue(1, 3'd2, 2'd0, 0, "R7");
        issue(1, 3'd5, 2'd0, 0, "R7");
        // R6: exact half with odd upper word rounds up to even
        load(1'b0, 1'b1, 24'h000003);
        issue(1, 3'd1, 2'd0, 1, "R5");
        issue(1, 3'd4, 2'd2, 1, "R6");
        // R6: above half rounds up
        load(1'b1, 1'b1, 24'h200000);
        issue(1, 3'd1, 2'd0, 0, "R5");
        issue(1, 3'd4, 2'd3, 0, "R6");
        // R7: below half rounds down
        load(1'b1, 1'b0, 24'h100000);
        issue(1, 3'd3, 2'd0, 0, "R7");
        issue(1, 3'd5, 2'd0, 0, "R7");
        check_rd(1'b0, "R9");

        // R10: positive overflow into guard bits
        load(1'b0, 1'b0, 24'h7FFFFF);
        load(1'b1, 1'b0, 24'h7FFFFF);
        issue(1, 3'd2, 2'd0, 0, "R4");
        issue(1, 3'd3, 2'd0, 0, "R4");
        check_rd(1'b0, "R10");
        // R10: negative overflow
        load(1'b1, 1'b1, 24'h800000);
        issue(1, 3'd2, 2'd1, 1, "R3");
        issue(1, 3'd3, 2'd1, 1, "R4");
        issue(1, 3'd3, 2'd1, 1, "R4");
        check_rd(1'b1, "R10");
        // R12: -1 x -1
        load(1'b0, 1'b1, 24'h800000);
        issue(1, 3'd2, 2'd3, 1, "R12");
        check_rd(1'b1, "R12");
        check_rd(1'b0, "R10");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule